// File: doc/BRIEF.md
# Time-of-Day Counter with Rate Trim and Offset Correction

This block keeps a running time of day, split into a 32-bit seconds count and a sub-second count, for hardware timestamping. It runs from a local reference clock. On each clock it adds a programmable sub-second step. In coarse mode the step is added on every clock. In fine mode the step is added only when a 32-bit rate accumulator, which adds a programmable addend every clock, carries out. Trimming the addend therefore trims the rate of the counter.

The sub-second field counts in one of two units:
- Decimal mode counts nanoseconds and carries into seconds at one billion.
- Binary mode uses steps of roughly 0.465 ns and carries at 2^31.

Control software issues three commands, each started by a request pulse:
- Load the time.
- Latch a new addend.
- Apply a signed offset.

Each command shows a busy flag that drops by itself once the work is done. A subtract offset arrives in wrap-around form. The seconds word holds 2^32 minus the amount, and the sub-second word holds the rollover value minus the amount. The block adds both words and then applies a carry or a borrow into seconds.

The block has no streaming data path. Every pin is plain control or status, so no valid/ready back-pressure applies.

Top module: `tod_counter`

## Requirements
- R1: After reset, seconds and sub-seconds read zero, all busy flags are low, and the addend holds 2^31.
- R2: With fine_mode low and no command being applied, the sub-second count grows by sub_inc on every clock.
- R3: With decimal_mode high, a sub-second sum of 1,000,000,000 or more wraps by subtracting 1,000,000,000. Seconds increment in the same clock edge, and seconds wrap from 2^32-1 to 0.
- R4: With decimal_mode low, a sub-second sum of 2^31 or more wraps by subtracting 2^31, and seconds increment in the same clock edge.
- R5: With fine_mode high, the accumulator adds the addend every clock, and sub-seconds grow by sub_inc only on a clock where the accumulator carries out. With an addend of 2^31, exactly N steps occur in any 2N consecutive clocks.
- R6: A req_init pulse sampled at edge k makes busy_init high after edge k. At edge k+1, seconds take set_sec and sub-seconds take set_sub[30:0], and the tick of that edge is dropped.
- R7: A req_addend pulse sampled at edge k latches addend_val as the addend at edge k+1. With an addend of 2^30, exactly N steps occur in any 4N clocks, and with an addend of 0 the time does not move.
- R8: A req_update with set_neg low adds {set_sec, set_sub} to the time at edge k+1. A sub-second sum at or above the rollover subtracts the rollover and carries one into seconds. The tick of that edge is dropped.
- R9: A req_update with set_neg high takes set_sec as 2^32 minus the seconds amount and set_sub as the rollover minus the sub-second amount (0 to rollover). The result equals the time minus the amount, modulo 2^32 seconds.
- R10: Only one command runs at a time. Requests that arrive while a busy flag is high are dropped. Simultaneous requests are taken in the order init, update, addend.
- R11: A busy flag is high for exactly two clocks, and it falls on the edge after the edge that applies its command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fine_mode | input | 1 | 1: step gated by accumulator carry; 0: step every clock |
| decimal_mode | input | 1 | 1: sub-seconds roll at 10^9; 0: roll at 2^31 |
| sub_inc | input | 8 | Sub-second step |
| addend_val | input | 32 | Addend value taken by req_addend |
| set_sec | input | 32 | Seconds word for load or offset |
| set_sub | input | 32 | Sub-second word for load or offset |
| set_neg | input | 1 | Offset direction: 1 subtract, 0 add |
| req_init | input | 1 | Request to load the time |
| req_addend | input | 1 | Request to latch the addend |
| req_update | input | 1 | Request to apply the offset |
| tod_sec | output | 32 | Current seconds |
| tod_subsec | output | 31 | Current sub-seconds |
| busy_init | output | 1 | Load command in progress |
| busy_addend | output | 1 | Addend command in progress |
| busy_update | output | 1 | Offset command in progress |

## Verification
The bench sweeps several step sizes through the sub-second rollover in both units, including a seconds wrap at 2^32-1. A wrong compare bound or a late carry would show there as a value one rollover too large, or as seconds that lag by a clock. Offsets are tried with and without carry and borrow, including a zero sub-second amount and a subtraction below zero seconds. A missing or misplaced borrow would leave the result one second off. Fine-mode windows of exact length check that the rate follows the addend and that an addend of zero stops the time. Requests sent during a busy window must leave the time and the other busy flag unchanged.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  // one-hot positions of the command kinds; lower index = higher priority
  localparam int CMD_INIT   = 0;
  localparam int CMD_UPDATE = 1;
  localparam int CMD_ADDEND = 2;
  localparam int CMD_N      = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_APPLY  = 2'd1,
    SEQ_RETIRE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/tod_cmd_seq.sv
`timescale 1ns/1ps
module tod_cmd_seq
  import tod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_N-1:0] req,
  output logic [CMD_N-1:0] apply,
  output logic [CMD_N-1:0] busy
);
  seq_state_e       state_q;
  logic [CMD_N-1:0] kind_q;
  logic [CMD_N-1:0] pick;

  // fixed priority: lowest index wins
  always_comb begin
    pick = '0;
    for (int i = CMD_N - 1; i >= 0; i--) begin
      if (req[i]) pick = CMD_N'(1) << i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      kind_q  <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (|req) begin
            state_q <= SEQ_APPLY;
            kind_q  <= pick;
          end
        end
        SEQ_APPLY:  state_q <= SEQ_RETIRE;
        SEQ_RETIRE: begin
          state_q <= SEQ_IDLE;
          kind_q  <= '0;
        end
        default:    state_q <= SEQ_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < CMD_N; g++) begin : g_flags
    assign apply[g] = (state_q == SEQ_APPLY) && kind_q[g];
    assign busy[g]  = (state_q != SEQ_IDLE) && kind_q[g];
  end
endmodule

// File: rtl/tod_rate_accum.sv
`timescale 1ns/1ps
module tod_rate_accum #(
  parameter int                ACC_W      = 32,
  parameter logic [ACC_W-1:0]  ADDEND_RST = ACC_W'(1) << (ACC_W - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fine_en,
  input  logic [ACC_W-1:0] addend_new,
  input  logic             addend_take,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] addend_q;
  logic [ACC_W:0]   acc_sum;

  assign acc_sum = {1'b0, acc_q} + {1'b0, addend_q};
  assign tick    = fine_en ? acc_sum[ACC_W] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      addend_q <= ADDEND_RST;
    end else begin
      acc_q <= acc_sum[ACC_W-1:0];
      if (addend_take) addend_q <= addend_new;
    end
  end
endmodule

// File: rtl/tod_time_core.sv
`timescale 1ns/1ps
module tod_time_core #(
  parameter int          SEC_W    = 32,
  parameter int          SUB_W    = 31,
  parameter int          INC_W    = 8,
  parameter int unsigned DEC_ROLL = 1_000_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             decimal_mode,
  input  logic [INC_W-1:0] step,
  input  logic             tick,
  input  logic             do_load,
  input  logic             do_offset,
  input  logic             off_neg,
  input  logic [SEC_W-1:0] in_sec,
  input  logic [SUB_W:0]   in_sub,
  output logic [SEC_W-1:0] sec_q,
  output logic [SUB_W-1:0] sub_q
);
  localparam int SX = SUB_W + 2;

  logic [SX-1:0]    roll;
  logic [SX-1:0]    step_sum;
  logic [SX-1:0]    off_sum;
  logic             step_wrap;
  logic             off_wrap;
  logic [SEC_W-1:0] sec_adj;

  assign roll      = decimal_mode ? SX'(DEC_ROLL) : (SX'(1) << SUB_W);
  assign step_sum  = SX'(sub_q) + SX'(step);
  assign step_wrap = step_sum >= roll;
  assign off_sum   = SX'(sub_q) + SX'(in_sub);
  assign off_wrap  = off_sum >= roll;

  // carry (+1) for add, borrow (-1) for subtract
  always_comb begin
    if (off_neg && !off_wrap)      sec_adj = '1;
    else if (!off_neg && off_wrap) sec_adj = SEC_W'(1);
    else                           sec_adj = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= '0;
      sub_q <= '0;
    end else if (do_load) begin
      sec_q <= in_sec;
      sub_q <= in_sub[SUB_W-1:0];
    end else if (do_offset) begin
      sec_q <= sec_q + in_sec + sec_adj;
      sub_q <= off_wrap ? SUB_W'(off_sum - roll) : SUB_W'(off_sum);
    end else if (tick) begin
      sec_q <= sec_q + SEC_W'(step_wrap);
      sub_q <= step_wrap ? SUB_W'(step_sum - roll) : SUB_W'(step_sum);
    end
  end
endmodule

// File: rtl/tod_counter.sv
`timescale 1ns/1ps
module tod_counter
  import tod_pkg::*;
#(
  parameter int          SEC_W    = 32,
  parameter int          SUB_W    = 31,
  parameter int          INC_W    = 8,
  parameter int          ACC_W    = 32,
  parameter int unsigned DEC_ROLL = 1_000_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fine_mode,
  input  logic             decimal_mode,
  input  logic [INC_W-1:0] sub_inc,
  input  logic [ACC_W-1:0] addend_val,
  input  logic [SEC_W-1:0] set_sec,
  input  logic [SUB_W:0]   set_sub,
  input  logic             set_neg,
  input  logic             req_init,
  input  logic             req_addend,
  input  logic             req_update,
  output logic [SEC_W-1:0] tod_sec,
  output logic [SUB_W-1:0] tod_subsec,
  output logic             busy_init,
  output logic             busy_addend,
  output logic             busy_update
);
  logic [CMD_N-1:0] req_vec;
  logic [CMD_N-1:0] apply_vec;
  logic [CMD_N-1:0] busy_vec;
  logic             core_tick;
  logic             do_init;
  logic             do_update;

  assign req_vec[CMD_INIT]   = req_init;
  assign req_vec[CMD_UPDATE] = req_update;
  assign req_vec[CMD_ADDEND] = req_addend;
  assign do_init     = apply_vec[CMD_INIT];
  assign do_update   = apply_vec[CMD_UPDATE];
  assign busy_init   = busy_vec[CMD_INIT];
  assign busy_update = busy_vec[CMD_UPDATE];
  assign busy_addend = busy_vec[CMD_ADDEND];

  tod_cmd_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_vec),
    .apply (apply_vec),
    .busy  (busy_vec)
  );

  tod_rate_accum #(.ACC_W(ACC_W)) u_rate (
    .clk         (clk),
    .rst_n       (rst_n),
    .fine_en     (fine_mode),
    .addend_new  (addend_val),
    .addend_take (apply_vec[CMD_ADDEND]),
    .tick        (core_tick)
  );

  tod_time_core #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W), .DEC_ROLL(DEC_ROLL)
  ) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .decimal_mode (decimal_mode),
    .step         (sub_inc),
    .tick         (core_tick),
    .do_load      (do_init),
    .do_offset    (do_update),
    .off_neg      (set_neg),
    .in_sec       (set_sec),
    .in_sub       (set_sub),
    .sec_q        (tod_sec),
    .sub_q        (tod_subsec)
  );
endmodule

// File: rtl/tod_counter_chk.sv
`timescale 1ns/1ps
module tod_counter_chk #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             do_init,
  input logic             do_update,
  input logic [SEC_W-1:0] set_sec,
  input logic [SUB_W:0]   set_sub,
  input logic [SEC_W-1:0] tod_sec,
  input logic [SUB_W-1:0] tod_subsec,
  input logic             busy_init,
  input logic             busy_addend,
  input logic             busy_update
);
  logic busy_any;
  assign busy_any = busy_init | busy_addend | busy_update;

  // R10: at most one command in flight
  a_r10_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_init, busy_addend, busy_update}));

  // R11: busy lasts exactly two clocks
  a_r11_busy_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_any) |=> busy_any ##1 !busy_any);

  // R6: load lands on the next edge
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    do_init |=> (tod_sec == $past(set_sec)) && (tod_subsec == $past(set_sub[SUB_W-1:0])));

  // R5: no accumulator step and no command means the time holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !do_init && !do_update) |=> $stable(tod_sec) && $stable(tod_subsec));

  // R3: outside commands, seconds only ever move by one
  a_r3_carry_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(do_init) && !$past(do_update) && (tod_sec != $past(tod_sec)))
      |-> (tod_sec == $past(tod_sec) + SEC_W'(1)));
endmodule

bind tod_counter tod_counter_chk #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (core_tick),
  .do_init     (do_init),
  .do_update   (do_update),
  .set_sec     (set_sec),
  .set_sub     (set_sub),
  .tod_sec     (tod_sec),
  .tod_subsec  (tod_subsec),
  .busy_init   (busy_init),
  .busy_addend (busy_addend),
  .busy_update (busy_update)
);

// File: tb/tod_counter_bench.sv
`timescale 1ns/1ps
module tod_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fine_mode = 1'b0, decimal_mode = 1'b1;
  logic [7:0]  sub_inc = '0;
  logic [31:0] addend_val = '0, set_sec = '0, set_sub = '0;
  logic        set_neg = 1'b0, req_init = 1'b0, req_addend = 1'b0, req_update = 1'b0;
  logic [31:0] tod_sec;
  logic [30:0] tod_subsec;
  logic        busy_init, busy_addend, busy_update;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  tod_counter u_tod_counter (
    .clk(clk), .rst_n(rst_n), .fine_mode(fine_mode), .decimal_mode(decimal_mode),
    .sub_inc(sub_inc), .addend_val(addend_val), .set_sec(set_sec), .set_sub(set_sub),
    .set_neg(set_neg), .req_init(req_init), .req_addend(req_addend), .req_update(req_update),
    .tod_sec(tod_sec), .tod_subsec(tod_subsec), .busy_init(busy_init),
    .busy_addend(busy_addend), .busy_update(busy_update)
  );

  function automatic longint unsigned roll_of(bit dec);
    return dec ? 64'd1000000000 : 64'h8000_0000;
  endfunction

  function automatic longint unsigned span_of(bit dec);
    return roll_of(dec) << 32;
  endfunction

  function automatic longint unsigned now_total(bit dec);
    return longint'(tod_sec) * roll_of(dec) + longint'(tod_subsec);
  endfunction

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_init(logic [31:0] s, logic [31:0] ss);
    @(negedge clk); set_sec = s; set_sub = ss; req_init = 1'b1;
    @(negedge clk); req_init = 1'b0; chk("R11 busy_init up", busy_init, 1);
    @(negedge clk);
    chk("R6 load seconds", tod_sec, s);
    chk("R6 load subsec", tod_subsec, ss);
    chk("R11 busy_init held", busy_init, 1);
    @(negedge clk); chk("R11 busy_init down", busy_init, 0);
  endtask

  task automatic do_addend(logic [31:0] a);
    @(negedge clk); addend_val = a; req_addend = 1'b1;
    @(negedge clk); req_addend = 1'b0; chk("R11 busy_addend up", busy_addend, 1);
    @(negedge clk); chk("R11 busy_addend held", busy_addend, 1);
    @(negedge clk); chk("R11 busy_addend down", busy_addend, 0);
  endtask

  task automatic do_offset(string tag, bit dec, bit neg, longint unsigned amt_s,
                           longint unsigned amt_ss);
    longint unsigned cur, off, exp, m;
    m   = span_of(dec);
    off = amt_s * roll_of(dec) + amt_ss;
    @(negedge clk);
    set_neg = neg;
    set_sec = neg ? 32'(64'h1_0000_0000 - amt_s) : 32'(amt_s);
    set_sub = neg ? 32'(roll_of(dec) - amt_ss) : 32'(amt_ss);
    req_update = 1'b1;
    @(negedge clk); req_update = 1'b0; cur = now_total(dec);
    exp = neg ? (cur + m - off) % m : (cur + off) % m;
    @(negedge clk);
    chk(tag, now_total(dec), exp);
    chk("R11 busy_update held", busy_update, 1);
    @(negedge clk); chk("R11 busy_update down", busy_update, 0);
    set_neg = 1'b0;
  endtask

  task automatic sweep(string tag, bit dec, logic [31:0] start_sec);
    int steps[4] = '{1, 7, 40, 255};
    longint unsigned base;
    foreach (steps[i]) begin
      @(negedge clk); sub_inc = 8'(steps[i]);
      do_init(start_sec, 32'(roll_of(dec) - 3 * steps[i] - 1));
      base = now_total(dec);
      for (int n = 1; n <= 8; n++) begin
        @(negedge clk);
        chk(tag, now_total(dec), (base + longint'(n) * steps[i]) % span_of(dec));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint unsigned base;
    repeat (3) @(negedge clk);
    chk("R1 reset seconds", tod_sec, 0);
    chk("R1 reset subsec", tod_subsec, 0);
    chk("R1 reset busy", {busy_init, busy_addend, busy_update}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle with zero step", now_total(1), 0);

    // coarse sweeps through rollover in both units
    decimal_mode = 1'b1;
    sweep("R2 R3 decimal step", 1, 32'd100);
    sweep("R3 seconds wrap", 1, 32'hFFFF_FFFF);
    decimal_mode = 1'b0;
    sweep("R2 R4 binary step", 0, 32'd77);

    // fine mode rate
    decimal_mode = 1'b1; fine_mode = 1'b1;
    @(negedge clk); sub_inc = 8'd20;
    do_init(32'd7, 32'd1000);
    base = now_total(1);
    repeat (20) @(negedge clk);
    chk("R5 R1 half-rate with reset addend", now_total(1), base + 10 * 20);
    do_addend(32'h4000_0000);
    base = now_total(1);
    repeat (40) @(negedge clk);
    chk("R7 quarter-rate addend", now_total(1), base + 10 * 20);
    do_addend(32'h0);
    base = now_total(1);
    repeat (30) @(negedge clk);
    chk("R7 zero addend stops time", now_total(1), base);
    do_addend(32'h8000_0000);
    fine_mode = 1'b0;

    // offsets, decimal
    @(negedge clk); sub_inc = 8'd5;
    do_init(32'd50, 32'd999_999_990);
    do_offset("R8 add with carry", 1, 0, 2, 15);
    do_offset("R8 add no carry", 1, 0, 0, 100);
    do_offset("R9 subtract with borrow", 1, 1, 1, 999_999_999);
    do_offset("R9 subtract whole seconds", 1, 1, 3, 0);
    do_init(32'd0, 32'd10);
    do_offset("R9 subtract below zero", 1, 1, 0, 50);
    // offsets, binary
    decimal_mode = 1'b0;
    do_init(32'd9, 32'h7FFF_FFD8);
    do_offset("R8 binary add carry", 0, 0, 1, 100);
    do_offset("R9 binary subtract", 0, 1, 2, 32'h7FFF_FFFF);
    decimal_mode = 1'b1;

    // R10: priority and drop while busy
    @(negedge clk);
    set_sec = 32'd40; set_sub = 32'd500; set_neg = 1'b0;
    req_init = 1'b1; req_update = 1'b1;
    @(negedge clk); req_init = 1'b0;
    chk("R10 update not taken", busy_update, 0);
    @(negedge clk);
    chk("R10 init wins", now_total(1), 40 * 64'd1000000000 + 500);
    chk("R10 update dropped", busy_update, 0);
    @(negedge clk); req_update = 1'b0;
    chk("R10 update still dropped", busy_update, 0);
    @(negedge clk);
    chk("R10 no late update", busy_update, 0);
    chk("R10 time untouched", now_total(1), 40 * 64'd1000000000 + 500 + 2 * 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule